// File: doc/BRIEF.md
# Clock Security Failover Controller

This block supervises an external crystal clock from the always-running internal RC clock domain. Software turns each oscillator on through a control register and reads back a ready bit for each. The ready bit rises once the oscillator has been on for a programmable settling time. The external clock may drive the system only when software asks for it and its ready bit is set. A PLL source select bit sits in the same register and is frozen for as long as the PLL enable bit is set.

When monitoring is armed and the external oscillator is ready, the block counts internal-clock cycles between rising edges of the external clock, taken through a two-flop synchronizer. If sixteen cycles pass without an edge, the block declares a failure. It then switches the external oscillator off, moves the system back to the internal clock, sends a one-cycle pulse to the brake input of the motor-control timer and raises a non-maskable interrupt request. The interrupt stays pending in a sticky flag until software writes a one to the clear bit.

Top module: `clk_guard`

## Requirements
- R1: After reset the control register (address 0) reads 0x01, with only the internal oscillator enable (bit 0) set. The interrupt register (address 1) reads 0x00, and `nmi_req`, `brake_pulse` and `sys_clk_ext` are low.
- R2: A ready bit (bit 1 internal, bit 3 external) reads 1 exactly STABLE_CYCLES (64) clock cycles after its enable bit (bit 0 internal, bit 2 external) is written to 1. It reads 0 in the first cycle after the enable is written to 0.
- R3: `sys_clk_ext` is high only while the external-select bit (bit 7) and the external ready bit are both set.
- R4: A control write updates the PLL source bit (bit 6, mirrored on `pll_src_ext`) only when the PLL enable bit (bit 5) was 0 before that write. Otherwise the new source value is ignored.
- R5: With the monitor-enable bit (bit 4) and external ready set, a failure is declared once 16 consecutive internal cycles pass with no synchronized rising edge of `ext_clk`. Edge spacings of 4 or 12 cycles never cause a failure.
- R6: A failure clears the external enable (bit 2) and the external-select bit (bit 7), so `ext_osc_on` and `sys_clk_ext` drop in the cycle the failure takes effect.
- R7: Each failure produces a `brake_pulse` exactly one cycle long.
- R8: A failure sets the flag at bit 7 of the interrupt register, and `nmi_req` is high exactly while that flag is set. The flag rises in the same cycle as the brake pulse.
- R9: A write of 1 to bit 0 of the interrupt register clears the flag and `nmi_req`. A write with bit 0 at 0 leaves them set.
- R10: Once set, the failure flag stays set when the external clock starts toggling again.
- R11: With the monitor-enable bit at 0, a stopped external clock raises no failure and leaves the external enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC clock, clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External crystal clock under supervision |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 interrupt |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 interrupt |
| rd_data | output | 8 | Read data, combinational |
| int_osc_on | output | 1 | Internal oscillator enable |
| ext_osc_on | output | 1 | External oscillator enable |
| sys_clk_ext | output | 1 | System clock taken from the external source |
| pll_src_ext | output | 1 | PLL source select, 1 = external |
| brake_pulse | output | 1 | One-cycle timer brake event |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The detector is fed an external clock with an edge every 4 cycles, then every 12 cycles, and finally with the clock held still. The first two must stay silent, which separates a correct 16-cycle window from one that is too short. The stopped clock must trip within a bounded number of cycles, which catches a window that is too long or a detector that never fires. A stopped clock with monitoring off, and a clock that resumes after a failure, separate correct arming and a sticky flag from a detector that runs unconditionally or clears itself.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

    localparam int REG_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_INTR = 1'b1;

    // control register bit positions
    localparam int B_INT_ON  = 0;
    localparam int B_INT_RDY = 1;
    localparam int B_EXT_ON  = 2;
    localparam int B_EXT_RDY = 3;
    localparam int B_MON_ON  = 4;
    localparam int B_PLL_ON  = 5;
    localparam int B_PLL_SRC = 6;
    localparam int B_USE_EXT = 7;

    // interrupt register bit positions
    localparam int B_CLR  = 0;
    localparam int B_FAIL = 7;

    typedef struct packed {
        logic use_ext;
        logic pll_src;
        logic pll_on;
        logic mon_on;
        logic ext_on;
        logic int_on;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  fail;
        logic  brake;
    } guard_state_t;

endpackage

// File: rtl/clk_guard_ready_timer.sv
module clk_guard_ready_timer #(
    parameter int STABLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_on,
    output logic osc_rdy
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] DONE = CW'(STABLE_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!osc_on) begin
            cnt_d = '0;
        end else if (cnt_q != DONE) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // drops in the same cycle the enable goes low
    assign osc_rdy = osc_on && (cnt_q == DONE);

endmodule

// File: rtl/clk_guard_edge_watch.sv
module clk_guard_edge_watch #(
    parameter int MISS_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic armed,
    output logic miss_hit
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
    } watch_t;

    watch_t d, q;
    logic   rise;

    assign rise = q.sync[1] && !q.sync[2];

    always_comb begin
        d      = q;
        d.sync = {q.sync[1:0], ext_clk};
        if (!armed || rise) begin
            d.cnt = '0;
        end else if (q.cnt != LAST) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miss_hit = armed && !rise && (q.cnt == LAST);

endmodule

// File: rtl/clk_guard.sv
module clk_guard
    import clk_guard_pkg::*;
#(
    parameter int STABLE_CYCLES = 64,
    parameter int MISS_LIMIT    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             int_osc_on,
    output logic             ext_osc_on,
    output logic             sys_clk_ext,
    output logic             pll_src_ext,
    output logic             brake_pulse,
    output logic             nmi_req
);
    guard_state_t d, q;
    logic int_rdy, ext_rdy, armed, miss_hit, pll_on;
    logic unused_bits;

    assign unused_bits = ^{wr_data[B_INT_RDY], wr_data[B_EXT_RDY]};

    clk_guard_ready_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_int_rdy (
        .clk(clk), .rst_n(rst_n), .osc_on(q.ctrl.int_on), .osc_rdy(int_rdy)
    );

    clk_guard_ready_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_ext_rdy (
        .clk(clk), .rst_n(rst_n), .osc_on(q.ctrl.ext_on), .osc_rdy(ext_rdy)
    );

    assign armed = q.ctrl.mon_on && ext_rdy;

    clk_guard_edge_watch #(.MISS_LIMIT(MISS_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .armed(armed), .miss_hit(miss_hit)
    );

    always_comb begin
        d       = q;
        d.brake = 1'b0;
        if (wr_en && wr_addr == ADDR_CTRL) begin
            d.ctrl.int_on  = wr_data[B_INT_ON];
            d.ctrl.ext_on  = wr_data[B_EXT_ON];
            d.ctrl.mon_on  = wr_data[B_MON_ON];
            d.ctrl.pll_on  = wr_data[B_PLL_ON];
            d.ctrl.use_ext = wr_data[B_USE_EXT];
            if (!q.ctrl.pll_on) begin
                d.ctrl.pll_src = wr_data[B_PLL_SRC];
            end
        end
        if (wr_en && wr_addr == ADDR_INTR && wr_data[B_CLR]) begin
            d.fail = 1'b0;
        end
        // a failure overrides any write in the same cycle
        if (miss_hit) begin
            d.fail         = 1'b1;
            d.brake        = 1'b1;
            d.ctrl.ext_on  = 1'b0;
            d.ctrl.use_ext = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.ctrl.int_on <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[B_INT_ON]  = q.ctrl.int_on;
            rd_data[B_INT_RDY] = int_rdy;
            rd_data[B_EXT_ON]  = q.ctrl.ext_on;
            rd_data[B_EXT_RDY] = ext_rdy;
            rd_data[B_MON_ON]  = q.ctrl.mon_on;
            rd_data[B_PLL_ON]  = q.ctrl.pll_on;
            rd_data[B_PLL_SRC] = q.ctrl.pll_src;
            rd_data[B_USE_EXT] = q.ctrl.use_ext;
        end else begin
            rd_data[B_FAIL] = q.fail;
        end
    end

    assign pll_on      = q.ctrl.pll_on;
    assign int_osc_on  = q.ctrl.int_on;
    assign ext_osc_on  = q.ctrl.ext_on;
    assign sys_clk_ext = q.ctrl.use_ext && ext_rdy;
    assign pll_src_ext = q.ctrl.pll_src;
    assign brake_pulse = q.brake;
    assign nmi_req     = q.fail;

endmodule

// File: rtl/clk_guard_checker.sv
module clk_guard_checker (
    input logic clk,
    input logic rst_n,
    input logic brake_pulse,
    input logic nmi_req,
    input logic ext_osc_on,
    input logic sys_clk_ext,
    input logic ext_rdy,
    input logic pll_on,
    input logic pll_src_ext
);
    a_r7_brake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        brake_pulse |=> !brake_pulse);

    a_r8_nmi_with_brake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> brake_pulse);

    a_r6_failover_state: assert property (@(posedge clk) disable iff (!rst_n)
        brake_pulse |-> (!ext_osc_on && !sys_clk_ext && nmi_req));

    a_r3_ext_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_ext |-> ext_rdy);

    a_r2_ready_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_osc_on |-> !ext_rdy);

    a_r4_pll_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_on && $past(pll_on)) |-> $stable(pll_src_ext));
endmodule

bind clk_guard clk_guard_checker u_chk (
    .clk(clk), .rst_n(rst_n), .brake_pulse(brake_pulse), .nmi_req(nmi_req),
    .ext_osc_on(ext_osc_on), .sys_clk_ext(sys_clk_ext), .ext_rdy(ext_rdy),
    .pll_on(pll_on), .pll_src_ext(pll_src_ext)
);

// File: tb/clk_guard_bench.sv
module clk_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       int_osc_on, ext_osc_on, sys_clk_ext, pll_src_ext, brake_pulse, nmi_req;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  ext_run = 1;
    int  ext_half = 2;

    clk_guard u_clk_guard (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .int_osc_on(int_osc_on),
        .ext_osc_on(ext_osc_on), .sys_clk_ext(sys_clk_ext), .pll_src_ext(pll_src_ext),
        .brake_pulse(brake_pulse), .nmi_req(nmi_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // external clock: toggles on negedge-aligned instants
    initial begin
        forever begin
            if (ext_run) begin
                #(ext_half*CLK_PERIOD) ext_clk = ~ext_clk;
            end else begin
                #(CLK_PERIOD);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic addr, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic addr, output logic [7:0] val);
        rd_addr = addr;
        #1;
        val = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(1'b0, v); check("R1 ctrl", v, 8'h01);
        rd_reg(1'b1, v); check("R1 intr", v, 8'h00);
        check("R1 outs", {nmi_req, brake_pulse, sys_clk_ext}, 0);
    endtask

    task automatic t_ready();
        logic [7:0] v;
        wr_reg(1'b0, 8'h85);
        repeat (63) @(negedge clk);
        rd_reg(1'b0, v);
        check("R2 ext rdy at 63", v[3], 0);
        check("R3 sys ext before ready", sys_clk_ext, 0);
        @(negedge clk);
        rd_reg(1'b0, v);
        check("R2 ext rdy at 64", v[3], 1);
        check("R2 int rdy", v[1], 1);
        check("R3 sys ext after ready", sys_clk_ext, 1);
        wr_reg(1'b0, 8'h81);
        rd_reg(1'b0, v);
        check("R2 ext rdy drops", v[3], 0);
        check("R3 sys ext drops", sys_clk_ext, 0);
        wr_reg(1'b0, 8'h85);
        repeat (70) @(negedge clk);
        check("R3 sys ext back", sys_clk_ext, 1);
    endtask

    task automatic t_pll();
        wr_reg(1'b0, 8'hE5); check("R4 src set while off", pll_src_ext, 1);
        wr_reg(1'b0, 8'hA5); check("R4 src held while on", pll_src_ext, 1);
        wr_reg(1'b0, 8'h85); check("R4 src held on turn-off write", pll_src_ext, 1);
        wr_reg(1'b0, 8'h85); check("R4 src written when off", pll_src_ext, 0);
    endtask

    task automatic t_no_monitor();
        logic [7:0] v;
        ext_run = 0;
        repeat (40) @(negedge clk);
        rd_reg(1'b1, v); check("R11 no flag", v, 8'h00);
        rd_reg(1'b0, v); check("R11 ext still on", v[2], 1);
        check("R11 no nmi", nmi_req, 0);
        ext_run = 1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_patterns();
        int brakes = 0;
        wr_reg(1'b0, 8'h95);
        ext_half = 2;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (brake_pulse) brakes++;
        end
        check("R5 spacing 4 no fail", nmi_req, 0);
        ext_half = 6;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (brake_pulse) brakes++;
        end
        check("R5 spacing 12 no fail", nmi_req, 0);
        check("R5 no brake", brakes, 0);
        ext_half = 2;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_failure();
        logic [7:0] v;
        int brakes = 0;
        int first = -1;
        ext_run = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (brake_pulse) brakes++;
            if (nmi_req && first < 0) first = i;
        end
        check("R5 fail not early", int'(first >= 12), 1);
        check("R5 fail in time", int'(first >= 0 && first <= 24), 1);
        check("R7 single brake", brakes, 1);
        check("R8 nmi high", nmi_req, 1);
        rd_reg(1'b1, v); check("R8 flag bit7", v, 8'h80);
        rd_reg(1'b0, v);
        check("R6 ext off", v[2], 0);
        check("R6 select cleared", v[7], 0);
        check("R6 sys internal", sys_clk_ext, 0);
    endtask

    task automatic t_resume_clear();
        logic [7:0] v;
        ext_run = 1;
        repeat (50) @(negedge clk);
        check("R10 flag sticky", nmi_req, 1);
        wr_reg(1'b1, 8'h00);
        check("R9 zero write keeps", nmi_req, 1);
        wr_reg(1'b1, 8'h01);
        check("R9 clear nmi", nmi_req, 0);
        rd_reg(1'b1, v); check("R9 flag cleared", v, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ready();
        t_pll();
        t_no_monitor();
        t_patterns();
        t_failure();
        t_resume_clear();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule